// File: doc/BRIEF.md
# ATA Task-File Register Channel

This block holds the byte-wide task-file registers of one ATA channel that serves two drive slots. A host reaches it through single-cycle read and write strobes, a 4-bit register select and an 8-bit data bus. Through these it loads the per-slot parameter registers (sector count, sector number, cylinder low and high), the shared drive/head, features, command and device control registers, and it reads status and error back. Each slot carries a presence flag and a packet-device flag. An absent slot is of type none, a present slot without the packet flag is a disk, and a present slot with it is a packet device.

Soft reset runs in two phases. The rising edge of the control reset bit puts the channel into a busy state. The falling edge completes the reset and reinitialises both slots. A command engine outside this block sees the command code and a one-cycle command strobe. It writes status and error back through update hooks and asks for an interrupt, which the block gates with the control interrupt-disable bit. Command execution, the data port and DMA are not part of this block.

Register selects: 0 data (writes ignored, reads 0x00), 1 features on write and error on read, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 command on write and status on read, 8 device control on write and alternate status on read, 9 alternate address (read only). Selects 10 to 15 read 0x00 and ignore writes.

Top module: `ata_taskfile_chan`

## Requirements
- R1: After reset the control register is 0x08, so interrupts are enabled. Error reads 0x01, status 0x00 and drive/head 0x00. Both slots hold sector count 0x01, sector number 0x01 and cylinder 0x0000.
- R2: A write to select 6 stores the byte with bits 7 and 5 forced to 1. Bit 4 of the stored value picks the slot (0 or 1) and bits 3:0 hold the head number.
- R3: Writes to selects 2, 3, 4 and 5 update the copy of that register in both slots in the same cycle, whichever slot is selected.
- R4: Writing select 8 with bit 2 (soft reset) set, while it was clear, sets status to 0x90, error to 0x01, the command code to 0x00, and stores the control byte with bit 1 (interrupt disable) cleared.
- R5: Writing select 8 with bit 2 clear, while it was set, clears status bit 7 (busy), sets status bit 6 (ready) and zeroes drive/head bits 3:0. It also resets both slots to count 0x01 and number 0x01, with cylinder 0xEB14 for a packet device and 0x0000 otherwise.
- R6: A drive/head write that selects an absent slot sets error bit 2 (abort) and status bit 0 (error).
- R7: A read of select 9 returns 0xFF, even when the selected slot is absent.
- R8: The interrupt output rises the cycle after an engine request only while control bit 1 is 0. It falls the cycle after control bit 1 is 1, and after a read of select 7. A read of select 8 returns status and leaves the interrupt unchanged.
- R9: An access with the wide flag set has no effect: nothing is written, no read data is returned and the interrupt is not cleared.
- R10: Read data and its valid flag appear one cycle after the read strobe. Select 1 returns the error register and select 7 returns status. A write to select 7 loads the command code and pulses the command strobe for one cycle.
- R11: Engine updates of status or error take effect the cycle after their strobe. A host write effect on the same register in the same cycle takes precedence.
- R12: While the selected slot is absent, a read of select 6 returns 0xA0 and a read of any other select except 9 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Single-cycle write strobe |
| host_rd_en | input | 1 | Single-cycle read strobe |
| host_sel | input | 4 | Register select |
| host_wide | input | 1 | Access wider than one byte (ignored) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| host_rvalid | output | 1 | Read data valid |
| slot_present | input | 2 | Presence flag per slot |
| slot_packet | input | 2 | Packet-device flag per slot |
| eng_st_we | input | 1 | Engine status update strobe |
| eng_st_val | input | 8 | Engine status value |
| eng_er_we | input | 1 | Engine error update strobe |
| eng_er_val | input | 8 | Engine error value |
| eng_irq_req | input | 1 | Engine interrupt request |
| feat_val | output | 8 | Current features register |
| cmd_code | output | 8 | Current command code |
| cmd_stb | output | 1 | One-cycle strobe after a command write |
| chan_irq | output | 1 | Channel interrupt request |

## Verification
Every register effect of a write, and of an engine hook strobe, is visible to a read issued on the next cycle. That read returns its data one cycle after its strobe. The driver therefore queues each expected value when it raises the read strobe, and the monitor compares the queued value with the result only on the falling clock edge at which the valid flag is high. The interrupt output and the command strobe change one edge after their cause, so the bench samples them directly at the falling edge that follows that edge. The bench also checks the interrupt at the falling edge that ends a status read or an alternate-status read. It checks the valid flag the cycle after a wide read, to confirm that no result appears.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
   localparam int TF_SEL_W = 4;

   typedef enum logic [TF_SEL_W-1:0] {
      SEL_DATA = 4'd0,
      SEL_FEAT = 4'd1,
      SEL_CNT  = 4'd2,
      SEL_SNUM = 4'd3,
      SEL_CYLL = 4'd4,
      SEL_CYLH = 4'd5,
      SEL_DEVH = 4'd6,
      SEL_CMD  = 4'd7,
      SEL_DCTL = 4'd8,
      SEL_ADR  = 4'd9
   } tf_sel_e;

   // control register bits
   localparam int CTL_NIEN = 1;
   localparam int CTL_SRST = 2;
   // status register bits
   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_ERR  = 0;
   // error register bits
   localparam int ER_ABRT = 2;
   // drive/head fields
   localparam int DH_DEV  = 4;

   localparam logic [7:0] CTL_INIT    = 8'h08;
   localparam logic [7:0] ERR_INIT    = 8'h01;
   localparam logic [7:0] ST_IN_RESET = 8'h90;
   localparam logic [7:0] DH_FIXED    = 8'hA0;
   localparam logic [7:0] ADR_IDLE    = 8'hFF;
endpackage

// File: rtl/ata_tf_slot.sv
module ata_tf_slot #(
   parameter int          DW      = 8,
   parameter logic [15:0] PKT_CYL = 16'hEB14,
   parameter logic [15:0] DSK_CYL = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cnt,
   input  logic          wr_snum,
   input  logic          wr_cyll,
   input  logic          wr_cylh,
   input  logic [DW-1:0] wdata,
   input  logic          slot_rst,
   input  logic          is_packet,
   output logic [DW-1:0] cnt_q,
   output logic [DW-1:0] snum_q,
   output logic [DW-1:0] cyll_q,
   output logic [DW-1:0] cylh_q
);
   localparam logic [DW-1:0] ONE = DW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= ONE;
         snum_q <= ONE;
         cyll_q <= '0;
         cylh_q <= '0;
      end else if (slot_rst) begin
         cnt_q  <= ONE;
         snum_q <= ONE;
         cyll_q <= is_packet ? PKT_CYL[DW-1:0]  : DSK_CYL[DW-1:0];
         cylh_q <= is_packet ? PKT_CYL[15:DW]   : DSK_CYL[15:DW];
      end else begin
         if (wr_cnt)  cnt_q  <= wdata;
         if (wr_snum) snum_q <= wdata;
         if (wr_cyll) cyll_q <= wdata;
         if (wr_cylh) cylh_q <= wdata;
      end
   end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
   import ata_tf_pkg::*;
#(
   parameter int DW = 8,
   parameter int NS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic [TF_SEL_W-1:0] sel,
   input  logic [DW-1:0]       wdata,
   input  logic                rd_status,
   input  logic [NS-1:0]       present,
   input  logic                st_we,
   input  logic [DW-1:0]       st_val,
   input  logic                er_we,
   input  logic [DW-1:0]       er_val,
   input  logic                irq_req,
   output logic [DW-1:0]       status_q,
   output logic [DW-1:0]       err_q,
   output logic [DW-1:0]       dh_q,
   output logic [DW-1:0]       feat_q,
   output logic [DW-1:0]       cmd_q,
   output logic                cmd_stb,
   output logic                irq_q,
   output logic                slot_rst
);
   logic [DW-1:0] ctl_q;
   logic          wr_dctl, srst_rise, srst_fall, wr_devh, new_absent;

   assign wr_dctl    = host_wr && (sel == SEL_DCTL);
   assign wr_devh    = host_wr && (sel == SEL_DEVH);
   assign srst_rise  = wr_dctl &&  wdata[CTL_SRST] && !ctl_q[CTL_SRST];
   assign srst_fall  = wr_dctl && !wdata[CTL_SRST] &&  ctl_q[CTL_SRST];
   assign slot_rst   = srst_fall;
   assign new_absent = !present[wdata[DH_DEV]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q    <= CTL_INIT;
         status_q <= '0;
         err_q    <= ERR_INIT;
         dh_q     <= '0;
         feat_q   <= '0;
         cmd_q    <= '0;
         cmd_stb  <= 1'b0;
      end else begin
         cmd_stb <= 1'b0;
         if (st_we) status_q <= st_val;
         if (er_we) err_q    <= er_val;
         if (host_wr) begin
            unique case (sel)
               SEL_FEAT: feat_q <= wdata;
               SEL_DEVH: begin
                  dh_q <= wdata | DH_FIXED;
                  if (new_absent) begin
                     err_q    <= err_q    | (DW'(1) << ER_ABRT);
                     status_q <= status_q | (DW'(1) << ST_ERR);
                  end
               end
               SEL_CMD: begin
                  cmd_q   <= wdata;
                  cmd_stb <= 1'b1;
               end
               SEL_DCTL: begin
                  if (srst_rise) begin
                     status_q <= ST_IN_RESET;
                     err_q    <= ERR_INIT;
                     cmd_q    <= '0;
                     ctl_q    <= wdata & ~(DW'(1) << CTL_NIEN);
                  end else if (srst_fall) begin
                     status_q <= (status_q & ~(DW'(1) << ST_BSY)) | (DW'(1) << ST_DRDY);
                     dh_q     <= {dh_q[DW-1:4], 4'h0};
                     ctl_q    <= wdata;
                  end else begin
                     ctl_q <= wdata;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                irq_q <= 1'b0;
      else if (ctl_q[CTL_NIEN])  irq_q <= 1'b0;
      else if (irq_req)          irq_q <= 1'b1;
      else if (rd_status)        irq_q <= 1'b0;
   end

   assert_devh_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_devh |=> (dh_q[7] && dh_q[5]));
   assert_srst_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      srst_rise |=> (status_q == ST_IN_RESET && err_q == ERR_INIT && cmd_q == '0 && !ctl_q[CTL_NIEN]));
   assert_srst_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      srst_fall |=> (!status_q[ST_BSY] && status_q[ST_DRDY] && dh_q[3:0] == 4'h0));
   assert_absent_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_devh && new_absent) |=> (status_q[ST_ERR] && err_q[ER_ABRT]));
   assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CTL_NIEN] |=> !irq_q);
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
   import ata_tf_pkg::*;
#(
   parameter int DW     = 8,
   parameter bit RD_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_go,
   input  logic [TF_SEL_W-1:0] sel,
   input  logic                sel_present,
   input  logic [DW-1:0]       status_q,
   input  logic [DW-1:0]       err_q,
   input  logic [DW-1:0]       dh_q,
   input  logic [DW-1:0]       cnt_q,
   input  logic [DW-1:0]       snum_q,
   input  logic [DW-1:0]       cyll_q,
   input  logic [DW-1:0]       cylh_q,
   output logic [DW-1:0]       rdata,
   output logic                rvalid
);
   logic [DW-1:0] rd_mux;

   always_comb begin
      rd_mux = '0;
      if (sel == SEL_ADR) begin
         rd_mux = ADR_IDLE;
      end else if (!sel_present) begin
         rd_mux = (sel == SEL_DEVH) ? DH_FIXED : '0;
      end else begin
         unique case (sel)
            SEL_FEAT: rd_mux = err_q;
            SEL_CNT:  rd_mux = cnt_q;
            SEL_SNUM: rd_mux = snum_q;
            SEL_CYLL: rd_mux = cyll_q;
            SEL_CYLH: rd_mux = cylh_q;
            SEL_DEVH: rd_mux = dh_q;
            SEL_CMD:  rd_mux = status_q;
            SEL_DCTL: rd_mux = status_q;
            default:  rd_mux = '0;
         endcase
      end
   end

   generate
      if (RD_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata  <= '0;
               rvalid <= 1'b0;
            end else begin
               rvalid <= rd_go;
               if (rd_go) rdata <= rd_mux;
            end
         end
         assert_adr_ff_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_go && sel == SEL_ADR) |=> (rvalid && rdata == ADR_IDLE));
      end else begin : g_comb
         assign rdata  = rd_mux;
         assign rvalid = rd_go;
      end
   endgenerate
endmodule

// File: rtl/ata_taskfile_chan.sv
module ata_taskfile_chan
   import ata_tf_pkg::*;
#(
   parameter int          DW      = 8,
   parameter int          NS      = 2,
   parameter int          SEL_W   = 4,
   parameter bit          RD_REG  = 1'b1,
   parameter logic [15:0] PKT_CYL = 16'hEB14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr_en,
   input  logic             host_rd_en,
   input  logic [SEL_W-1:0] host_sel,
   input  logic             host_wide,
   input  logic [DW-1:0]    host_wdata,
   output logic [DW-1:0]    host_rdata,
   output logic             host_rvalid,
   input  logic [NS-1:0]    slot_present,
   input  logic [NS-1:0]    slot_packet,
   input  logic             eng_st_we,
   input  logic [DW-1:0]    eng_st_val,
   input  logic             eng_er_we,
   input  logic [DW-1:0]    eng_er_val,
   input  logic             eng_irq_req,
   output logic [DW-1:0]    feat_val,
   output logic [DW-1:0]    cmd_code,
   output logic             cmd_stb,
   output logic             chan_irq
);
   localparam int SLOT_IW = (NS > 1) ? $clog2(NS) : 1;

   generate
      if (DW != 8)            begin : g_bad_dw  $error("task-file registers are byte wide"); end
      if (NS != 2)            begin : g_bad_ns  $error("channel serves exactly two slots"); end
      if (SEL_W != TF_SEL_W)  begin : g_bad_sel $error("select width must match package"); end
   endgenerate

   logic wr_ok, rd_ok, rd_status, slot_rst, cur_present;
   logic [DW-1:0] status_q, err_q, dh_q;
   logic [SLOT_IW-1:0] cur_slot;
   logic [DW-1:0] cnt_a [NS];
   logic [DW-1:0] snum_a[NS];
   logic [DW-1:0] cyll_a[NS];
   logic [DW-1:0] cylh_a[NS];

   assign wr_ok     = host_wr_en && !host_wide;
   assign rd_ok     = host_rd_en && !host_wide;
   assign rd_status = rd_ok && (host_sel == SEL_CMD);

   ata_tf_ctrl #(.DW(DW), .NS(NS)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr(wr_ok), .sel(host_sel), .wdata(host_wdata),
      .rd_status(rd_status), .present(slot_present),
      .st_we(eng_st_we), .st_val(eng_st_val), .er_we(eng_er_we), .er_val(eng_er_val),
      .irq_req(eng_irq_req), .status_q(status_q), .err_q(err_q), .dh_q(dh_q),
      .feat_q(feat_val), .cmd_q(cmd_code), .cmd_stb(cmd_stb), .irq_q(chan_irq),
      .slot_rst(slot_rst)
   );

   generate
      for (genvar g = 0; g < NS; g++) begin : g_slot
         ata_tf_slot #(.DW(DW), .PKT_CYL(PKT_CYL), .DSK_CYL(16'h0000)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_cnt (wr_ok && host_sel == SEL_CNT),
            .wr_snum(wr_ok && host_sel == SEL_SNUM),
            .wr_cyll(wr_ok && host_sel == SEL_CYLL),
            .wr_cylh(wr_ok && host_sel == SEL_CYLH),
            .wdata(host_wdata), .slot_rst(slot_rst), .is_packet(slot_packet[g]),
            .cnt_q(cnt_a[g]), .snum_q(snum_a[g]), .cyll_q(cyll_a[g]), .cylh_q(cylh_a[g])
         );
      end
   endgenerate

   assign cur_slot    = dh_q[DH_DEV +: SLOT_IW];
   assign cur_present = slot_present[cur_slot];

   ata_tf_rdmux #(.DW(DW), .RD_REG(RD_REG)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_go(rd_ok), .sel(host_sel), .sel_present(cur_present),
      .status_q(status_q), .err_q(err_q), .dh_q(dh_q),
      .cnt_q(cnt_a[cur_slot]), .snum_q(snum_a[cur_slot]),
      .cyll_q(cyll_a[cur_slot]), .cylh_q(cylh_a[cur_slot]),
      .rdata(host_rdata), .rvalid(host_rvalid)
   );

   assert_cnt_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && host_sel == SEL_CNT) |=> (cnt_a[0] == $past(host_wdata) && cnt_a[1] == $past(host_wdata)));
   assert_wide_noread_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_en && host_wide) |=> !host_rvalid);
endmodule

// File: tb/tb_ata_taskfile_chan.sv
module tb_ata_taskfile_chan;
   localparam int CLK_P = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, wide = 0;
   logic [3:0] sel = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic rvalid;
   logic [1:0] present = 2'b11, packet = 2'b10;
   logic st_we = 0, er_we = 0, irq_req = 0;
   logic [7:0] st_val = 0, er_val = 0;
   logic [7:0] feat, cmd;
   logic cstb, irq;

   int n_chk = 0, n_err = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   ata_taskfile_chan dut (
      .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_rd_en(rd_en), .host_sel(sel),
      .host_wide(wide), .host_wdata(wdata), .host_rdata(rdata), .host_rvalid(rvalid),
      .slot_present(present), .slot_packet(packet), .eng_st_we(st_we), .eng_st_val(st_val),
      .eng_er_we(er_we), .eng_er_val(er_val), .eng_irq_req(irq_req),
      .feat_val(feat), .cmd_code(cmd), .cmd_stb(cstb), .chan_irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] s, input logic [7:0] d, input logic w = 1'b0);
      @(negedge clk); wr_en = 1; sel = s; wdata = d; wide = w;
      @(negedge clk); wr_en = 0; wide = 0;
   endtask

   task automatic rd(input logic [3:0] s, input logic [7:0] exp, input string tag);
      @(negedge clk); rd_en = 1; sel = s;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk); rd_en = 0;
   endtask

   // monitor: compare each returned byte with the oldest queued expectation
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_err++;
            $display("FAIL R10: unexpected read data actual=%02h expected=none", rdata);
         end else begin
            check(tag_q.pop_front(), rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      check("R1 irq", {7'b0, irq}, 8'h00);
      check("R1 cmd", cmd, 8'h00);
      rd(1, 8'h01, "R1 error"); rd(7, 8'h00, "R1 status"); rd(6, 8'h00, "R1 devhead");
      rd(2, 8'h01, "R1 count"); rd(3, 8'h01, "R1 secnum"); rd(4, 8'h00, "R1 cyllo");
      // R3 parameter writes to both slots, R2 drive/head forcing
      wr(2, 8'h55); wr(3, 8'h66); wr(4, 8'h77); wr(5, 8'h88);
      wr(6, 8'h10);
      rd(6, 8'hB0, "R2 devhead slot1");
      rd(2, 8'h55, "R3 count slot1"); rd(3, 8'h66, "R3 secnum slot1");
      rd(4, 8'h77, "R3 cyllo slot1"); rd(5, 8'h88, "R3 cylhi slot1");
      wr(6, 8'h00);
      rd(6, 8'hA0, "R2 devhead slot0"); rd(2, 8'h55, "R3 count slot0");
      wr(6, 8'h05); rd(6, 8'hA5, "R2 head field");
      wr(1, 8'h03); check("R10 features", feat, 8'h03);
      // R11 engine hooks
      @(negedge clk); st_we = 1; st_val = 8'h58; er_we = 1; er_val = 8'h00;
      @(negedge clk); st_we = 0; er_we = 0;
      rd(7, 8'h58, "R11 status hook"); rd(1, 8'h00, "R11 error hook");
      // R11 host write wins over engine on same cycle
      @(negedge clk); st_we = 1; st_val = 8'h00; wr_en = 1; sel = 8; wdata = 8'h04;
      @(negedge clk); st_we = 0; wr_en = 0;
      rd(7, 8'h90, "R11 host precedence");
      wr(8, 8'h00);
      // R10 command write
      @(negedge clk); wr_en = 1; sel = 7; wdata = 8'hEC;
      @(negedge clk); wr_en = 0;
      check("R10 cmd_stb pulse", {7'b0, cstb}, 8'h01);
      check("R10 cmd_code", cmd, 8'hEC);
      @(negedge clk);
      check("R10 cmd_stb one cycle", {7'b0, cstb}, 8'h00);
      // R4 soft reset rising edge
      wr(6, 8'h13);
      @(negedge clk); st_we = 1; st_val = 8'h50; er_we = 1; er_val = 8'h00;
      @(negedge clk); st_we = 0; er_we = 0;
      wr(8, 8'h06);
      rd(7, 8'h90, "R4 status"); rd(1, 8'h01, "R4 error");
      check("R4 cmd cleared", cmd, 8'h00);
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      check("R4 nien cleared", {7'b0, irq}, 8'h01);
      rd(7, 8'h90, "R4 status again");
      // R5 soft reset falling edge
      wr(8, 8'h00);
      rd(7, 8'h50, "R5 status"); rd(6, 8'hB0, "R5 head zeroed");
      rd(2, 8'h01, "R5 count"); rd(3, 8'h01, "R5 secnum");
      rd(4, 8'h14, "R5 packet cyllo"); rd(5, 8'hEB, "R5 packet cylhi");
      wr(6, 8'h00);
      rd(4, 8'h00, "R5 disk cyllo"); rd(5, 8'h00, "R5 disk cylhi"); rd(2, 8'h01, "R5 disk count");
      // R8 interrupt behaviour
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      check("R8 irq raised", {7'b0, irq}, 8'h01);
      rd(8, 8'h50, "R8 alt status");
      check("R8 alt read keeps irq", {7'b0, irq}, 8'h01);
      rd(7, 8'h50, "R8 status read");
      check("R8 status read clears", {7'b0, irq}, 8'h00);
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      wr(8, 8'h02);
      @(negedge clk);
      check("R8 nien drops irq", {7'b0, irq}, 8'h00);
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      check("R8 gated request", {7'b0, irq}, 8'h00);
      wr(8, 8'h00);
      // R9 wide accesses ignored
      wr(2, 8'hAA, 1'b1);
      rd(2, 8'h01, "R9 wide write");
      @(negedge clk); irq_req = 1;
      @(negedge clk); irq_req = 0;
      @(negedge clk); rd_en = 1; wide = 1; sel = 7;
      @(negedge clk); rd_en = 0; wide = 0;
      check("R9 wide read no data", {7'b0, rvalid}, 8'h00);
      check("R9 wide read keeps irq", {7'b0, irq}, 8'h01);
      rd(7, 8'h50, "R9 status after");
      // R6 / R12 / R7 absent slot
      present = 2'b01;
      wr(6, 8'h10);
      rd(6, 8'hA0, "R12 absent devhead"); rd(1, 8'h00, "R12 absent error");
      rd(7, 8'h00, "R12 absent status"); rd(9, 8'hFF, "R7 absent adr");
      wr(6, 8'h00);
      rd(1, 8'h05, "R6 abort bit"); rd(7, 8'h51, "R6 error bit");
      rd(9, 8'hFF, "R7 present adr");
      repeat (3) @(negedge clk);
      check("R10 queue drained", 8'(exp_q.size()), 8'h00);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule